// File: doc/BRIEF.md
# Nibble-Written Character Bank Mapper

This block is the bank-switching core of a cartridge controller. It watches the processor write bus and keeps three kinds of state. The first is eight 1 KB character-memory bank numbers. Each of them is loaded four bits at a time, so a full 8-bit bank number takes two writes. The second is two switchable 8 KB program-memory bank numbers. The third is a one-bit nametable mirroring select. Two more program windows are tied to fixed banks. The surrounding chip supplies a single external base bit that lifts every character bank number into the upper 256-bank half.

All state lives in flip-flops that load on the rising clock edge that samples the write strobe. Every bank output therefore comes straight from a register. Address decoding uses only the top address nibble (the page) and address bits 1 and 0. The decoder sorts each strobed write into one named target: TGT_NONE, TGT_PRG_LO, TGT_PRG_HI, TGT_MIRROR or TGT_CHR. For a character write it also works out the slot and which half of the slot is written.

Top module: `nibchr_mapper`

## Requirements
- R1: While `rst_n` is low and after it is released, character slot i reads i, program bank 0 reads 0, program bank 1 reads 1, and `mirror_horiz` reads 0.
- R2: A strobed write whose page `cpu_addr[15:12]` is 0xB, 0xC, 0xD or 0xE writes character slot ((({A13,A12,A1}) + 2) mod 8). This maps B/A1=0 to slot 0, B/A1=1 to 1, C to 2 and 3, D to 4 and 5, and E to 6 and 7. No other slot changes.
- R3: `cpu_addr[0]`=0 replaces bits [3:0] of the slot and `cpu_addr[0]`=1 replaces bits [7:4]. The other half keeps its value.
- R4: A character write uses only `cpu_data[3:0]`. Data bits [7:4] have no effect.
- R5: A strobed write to page 0x8 loads `cpu_data` into program bank 0 (`prg_bank[0]`). A strobed write to page 0xA loads it into program bank 1 (`prg_bank[1]`).
- R6: `prg_bank[2]` is always 0x1E and `prg_bank[3]` is always 0x1F.
- R7: A strobed write to page 0x9 sets `mirror_horiz` to `cpu_data[0]` (1 = horizontal, 0 = vertical).
- R8: Each `chr_bank[i]` is 9 bits wide, {base, slot i}. The base is the value of `chr_hi_sel` at the previous rising edge, so it adds 256 when set.
- R9: A write to page 0x0–0x7 or 0xF, or any cycle with `cpu_wr` low, changes no output.
- R10: A write's effect appears on the outputs after the rising edge that samples `cpu_wr` high, and not before.
- R11: Address bits [11:2] play no part in decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor write address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| chr_hi_sel | input | 1 | External character base bit (adds 256) |
| prg_bank | output | 4x8 | Program bank numbers for the four 8 KB windows |
| chr_bank | output | 8x9 | Character bank numbers for the eight 1 KB windows |
| mirror_horiz | output | 1 | 1 = horizontal, 0 = vertical mirroring |

## Verification
Every result of a write is due exactly one rising edge after the strobe is sampled. The base bit likewise reaches the character outputs one edge after it changes. The bench drives inputs on falling edges and reads results on the next falling edge, which comes after the one capturing edge. For R10 it also reads once in the half cycle before that edge, while the strobe is already high, and expects the old value. Ignored writes are checked on the next falling edge by reading back the exact output they would have touched.

// File: rtl/nibchr_pkg.sv
package nibchr_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRG_LO,
        TGT_PRG_HI,
        TGT_MIRROR,
        TGT_CHR
    } wr_target_e;

    localparam int unsigned CHR_SLOT_BIAS = 2;
    localparam int unsigned PAGE_W        = 4;

endpackage

// File: rtl/nibchr_decode.sv
module nibchr_decode
    import nibchr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SLOT_W = 3
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr,
    output wr_target_e             target,
    output logic [SLOT_W-1:0]      slot_idx,
    output logic                   hi_nib,
    output logic [(1<<SLOT_W)-1:0] slot_hit
);
    localparam int unsigned SLOTS = 1 << SLOT_W;

    logic [PAGE_W-1:0] page;
    assign page = addr[ADDR_W-1 -: PAGE_W];

    always_comb begin
        target = TGT_NONE;
        if (wr) begin
            unique case (page)
                4'h8:                      target = TGT_PRG_LO;
                4'h9:                      target = TGT_MIRROR;
                4'hA:                      target = TGT_PRG_HI;
                4'hB, 4'hC, 4'hD, 4'hE:    target = TGT_CHR;
                default:                   target = TGT_NONE;
            endcase
        end
    end

    // slot = {A13, A12, A1} + bias, wrapping within the slot count
    assign slot_idx = SLOT_W'({addr[ADDR_W-3], addr[ADDR_W-4], addr[1]})
                    + SLOT_W'(CHR_SLOT_BIAS);
    assign hi_nib   = addr[0];

    for (genvar i = 0; i < SLOTS; i++) begin : g_hit
        assign slot_hit[i] = (target == TGT_CHR) && (slot_idx == SLOT_W'(i));
    end

endmodule

// File: rtl/chr_slot_reg.sv
module chr_slot_reg #(
    parameter int unsigned NIB_W     = 4,
    parameter logic [2*NIB_W-1:0] RESET_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic               hi_sel,
    input  logic [NIB_W-1:0]   nib_in,
    output logic [2*NIB_W-1:0] bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= RESET_VAL;
        end else if (wr_hit) begin
            if (hi_sel) bank_q[2*NIB_W-1:NIB_W] <= nib_in;
            else        bank_q[NIB_W-1:0]       <= nib_in;
        end
    end

    assert_untouched_slot_stable_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(bank_q));

    assert_high_half_kept_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_hit && !hi_sel) |=> $stable(bank_q[2*NIB_W-1:NIB_W]));

    assert_low_half_kept_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_hit && hi_sel) |=> $stable(bank_q[NIB_W-1:0]));

endmodule

// File: rtl/prg_mirror_regs.sv
module prg_mirror_regs
    import nibchr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_target_e        target,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] prg_lo_q,
    output logic [DATA_W-1:0] prg_hi_q,
    output logic              mirror_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prg_lo_q <= DATA_W'(0);
            prg_hi_q <= DATA_W'(1);
            mirror_q <= 1'b0;
        end else begin
            unique case (target)
                TGT_PRG_LO: prg_lo_q <= data;
                TGT_PRG_HI: prg_hi_q <= data;
                TGT_MIRROR: mirror_q <= data[0];
                default: ;
            endcase
        end
    end

    assert_mirror_load_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (target == TGT_MIRROR) |=> (mirror_q == $past(data[0])));

    assert_prg_hold_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (target == TGT_NONE) |=> ($stable(prg_lo_q) && $stable(prg_hi_q) && $stable(mirror_q)));

endmodule

// File: rtl/nibchr_mapper.sv
module nibchr_mapper
    import nibchr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PRG_WINS  = 4,
    parameter int unsigned CHR_SLOTS = 8,
    parameter logic [7:0]  PRG_FIX_A = 8'h1E,
    parameter logic [7:0]  PRG_FIX_B = 8'h1F
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-1:0]                      cpu_addr,
    input  logic [DATA_W-1:0]                      cpu_data,
    input  logic                                   cpu_wr,
    input  logic                                   chr_hi_sel,
    output logic [PRG_WINS-1:0][DATA_W-1:0]        prg_bank,
    output logic [CHR_SLOTS-1:0][DATA_W:0]         chr_bank,
    output logic                                   mirror_horiz
);
    localparam int unsigned SLOT_W = $clog2(CHR_SLOTS);
    localparam int unsigned NIB_W  = DATA_W / 2;

    wr_target_e           target;
    logic [SLOT_W-1:0]    slot_idx;
    logic                 hi_nib;
    logic [CHR_SLOTS-1:0] slot_hit;
    logic                 base_q;

    nibchr_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_decode (
        .addr     (cpu_addr),
        .wr       (cpu_wr),
        .target   (target),
        .slot_idx (slot_idx),
        .hi_nib   (hi_nib),
        .slot_hit (slot_hit)
    );

    for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        chr_slot_reg #(.NIB_W(NIB_W), .RESET_VAL(DATA_W'(i))) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (slot_hit[i]),
            .hi_sel (hi_nib),
            .nib_in (cpu_data[NIB_W-1:0]),
            .bank_q (slot_q)
        );
        assign chr_bank[i] = {base_q, slot_q};
    end

    prg_mirror_regs #(.DATA_W(DATA_W)) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .target   (target),
        .data     (cpu_data),
        .prg_lo_q (prg_bank[0]),
        .prg_hi_q (prg_bank[1]),
        .mirror_q (mirror_horiz)
    );

    assign prg_bank[2] = DATA_W'(PRG_FIX_A);
    assign prg_bank[3] = DATA_W'(PRG_FIX_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= 1'b0;
        else        base_q <= chr_hi_sel;
    end

    assert_base_set_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        chr_hi_sel |=> chr_bank[0][DATA_W]);

    assert_base_clear_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !chr_hi_sel |=> !chr_bank[CHR_SLOTS-1][DATA_W]);

    assert_one_slot_written_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit));

endmodule

// File: tb/nibchr_mapper_test.sv
module nibchr_mapper_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      cpu_addr = '0;
    logic [7:0]       cpu_data = '0;
    logic             cpu_wr = 1'b0;
    logic             chr_hi_sel = 1'b0;
    logic [3:0][7:0]  prg_bank;
    logic [7:0][8:0]  chr_bank;
    logic             mirror_horiz;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    nibchr_mapper uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_data     (cpu_data),
        .cpu_wr       (cpu_wr),
        .chr_hi_sel   (chr_hi_sel),
        .prg_bank     (prg_bank),
        .chr_bank     (chr_bank),
        .mirror_horiz (mirror_horiz)
    );

    // {addr, data, selector, expected}; selector 0-7 char slot, 8/9 prg bank 0/1, 10 mirror
    localparam logic [36:0] VEC [0:15] = '{
        {16'hB000, 8'h05, 4'd0,  9'h005},  // R2 R3 low half of slot 0
        {16'hB001, 8'h0A, 4'd0,  9'h0A5},  // R3 high half kept low
        {16'hB002, 8'hF3, 4'd1,  9'h003},  // R4 upper data ignored
        {16'hC003, 8'h07, 4'd3,  9'h073},  // R2 slot 3 high
        {16'hD000, 8'h0C, 4'd4,  9'h00C},  // R2 slot 4
        {16'hD006, 8'h09, 4'd5,  9'h009},  // R11 bit 2 ignored
        {16'hE001, 8'h02, 4'd6,  9'h026},  // R2 slot 6
        {16'hE7FF, 8'h01, 4'd7,  9'h017},  // R11 middle bits ignored
        {16'hC000, 8'h0E, 4'd2,  9'h00E},  // R2 slot 2
        {16'h8000, 8'h12, 4'd8,  9'h012},  // R5 prg 0
        {16'hAFFF, 8'h34, 4'd9,  9'h034},  // R5 prg 1
        {16'h9000, 8'h01, 4'd10, 9'h001},  // R7 horizontal
        {16'h9123, 8'hFE, 4'd10, 9'h000},  // R7 vertical from bit 0
        {16'hF000, 8'h55, 4'd0,  9'h0A5},  // R9 page F ignored
        {16'h7000, 8'h66, 4'd9,  9'h034},  // R9 page 7 ignored
        {16'hB800, 8'h04, 4'd0,  9'h0A4}   // R11 A11 ignored
    };

    function automatic logic [8:0] pick(input logic [3:0] sel);
        if (sel < 4'd8)       return chr_bank[sel[2:0]];
        else if (sel == 4'd8) return {1'b0, prg_bank[0]};
        else if (sel == 4'd9) return {1'b0, prg_bank[1]};
        else                  return {8'b0, mirror_horiz};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    task automatic check_defaults(input string req);
        for (int i = 0; i < 8; i++) check(req, chr_bank[i], 9'(i));
        check(req, {1'b0, prg_bank[0]}, 9'h000);
        check(req, {1'b0, prg_bank[1]}, 9'h001);
        check("R6", {1'b0, prg_bank[2]}, 9'h01E);
        check("R6", {1'b0, prg_bank[3]}, 9'h01F);
        check(req, {8'b0, mirror_horiz}, 9'h000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_defaults("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_defaults("R1 after reset");

        for (int v = 0; v < 16; v++) begin
            bus_write(VEC[v][36:21], VEC[v][20:13]);
            check($sformatf("vector %0d", v), pick(VEC[v][12:9]), VEC[v][8:0]);
        end

        // R9: strobe low leaves program bank 0 alone
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_data = 8'h77; cpu_wr = 1'b0;
        @(negedge clk);
        check("R9 strobe low", {1'b0, prg_bank[0]}, 9'h012);

        // R10: no change before the capturing edge, change after it
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_data = 8'h5A; cpu_wr = 1'b1;
        #1;
        check("R10 before edge", {1'b0, prg_bank[0]}, 9'h012);
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R10 after edge", {1'b0, prg_bank[0]}, 9'h05A);

        // R8: base bit, one edge later
        @(negedge clk);
        chr_hi_sel = 1'b1;
        #1;
        check("R8 before edge", chr_bank[3], 9'h073);
        @(negedge clk);
        check("R8 base set", chr_bank[3], 9'h173);
        check("R8 base set", chr_bank[7], 9'h117);
        @(negedge clk);
        chr_hi_sel = 1'b0;
        @(negedge clk);
        check("R8 base clear", chr_bank[3], 9'h073);

        // R6: fixed windows unaffected by writes
        check("R6 after writes", {1'b0, prg_bank[2]}, 9'h01E);
        check("R6 after writes", {1'b0, prg_bank[3]}, 9'h01F);

        // R1: reset again in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_defaults("R1 second reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule